// File: doc/BRIEF.md
# Margin DAC Control Registers

This block holds the digital side of a voltage-margining DAC. A parallel register port writes and reads two byte registers: a code register that stages the next DAC setting, and a configuration register that selects the half-scale range, requests a load, powers the converter and connects its output. The staged code becomes the active DAC setting only at the moment the load bit changes from 0 to 1. Rewriting the load bit without such a change leaves the active setting alone.

From the configuration byte and the active code, the block derives two values. The first is the half-scale voltage in millivolts, taken from an eight-entry table that is not evenly spaced. The second is a microvolt estimate of the DAC output. The estimate reads zero unless the converter is both powered and connected. A serial bus front end would drive the register port, and the analog converter would consume the active code and the two enable controls.

Top module: `mdac_ctrl`

## Requirements
- R1: After reset both registers read 0x00, the active code is 0x00, both enable outputs are 0 and the voltage estimate is 0.
- R2: Address 0xE3 is the code register. All 8 bits are written and read back unchanged.
- R3: Address 0xE4 is the configuration register. It has half-scale select in bits 5:3, load in bit 2, output connect in bit 1 and power enable in bit 0. Bits 7:6 always read back as 0.
- R4: A write to 0xE4 whose load bit is 1, while the stored load bit is 0, copies the code register into the active code in that same clock edge.
- R5: The active code does not change in any of these cases: a write to 0xE4 that keeps the load bit at 1, a write to 0xE4 that clears it, or any write to 0xE3.
- R6: Half-scale select values 0 to 7 give 400, 500, 600, 700, 800, 900, 1000 and 1200 mV, in that order.
- R7: When power enable and output connect are both 1, the voltage estimate equals floor(active_code × half_scale_mV × 1000 / 128) µV. In every other case it is 0.
- R8: The power output follows configuration bit 0 and the connect output follows configuration bit 1.
- R9: A write to any address other than 0xE3 or 0xE4 changes no state. A read of any such address returns 0x00.
- R10: Active code 0x80 yields exactly the half-scale voltage. Code 0xFF yields just under twice the half-scale voltage, for example 1992187 µV at a 1000 mV half scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register address for write and read |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| active_code | output | 8 | Code currently applied to the DAC |
| dac_power | output | 1 | Converter power enable |
| dac_connect | output | 1 | Output pin connect |
| half_scale_mv | output | 11 | Selected half-scale voltage in mV |
| vout_uv | output | 22 | Estimated output in µV, gated by both enables |

## Verification
Every result is due at the clock edge that accepts the write. This covers the stored registers, the active code on a load edge, the enables, the half-scale value and the gated estimate. None of these paths has an extra pipeline stage. Read data is combinational on the address. The bench therefore drives each write on a falling edge and checks all outputs on the next falling edge, half a cycle after the accepting edge. For reads, it settles the address for 1 ns and then samples `rd_data`.

// File: rtl/mdac_pkg.sv
package mdac_pkg;
  localparam logic [7:0] CODE_ADDR_DEF = 8'hE3;
  localparam logic [7:0] CFG_ADDR_DEF  = 8'hE4;

  // configuration byte field positions (decoded by neighbours)
  localparam int EN_BIT     = 0;
  localparam int OEN_BIT    = 1;
  localparam int LOAD_BIT   = 2;
  localparam int HS_LSB     = 3;
  localparam int HS_W       = 3;
  localparam int CFG_USED_W = 6;

  // half-scale table: evenly spaced 100 mV steps, except the top entry
  function automatic int unsigned hs_millivolts(input logic [HS_W-1:0] sel);
    if (sel == '1) return 32'd1200;
    return 32'd400 + 32'd100 * 32'(sel);
  endfunction

  // estimate in microvolts: code * mV * 1000 / 128, truncated
  function automatic int unsigned est_microvolts(input int unsigned code,
                                                 input int unsigned mv);
    int unsigned prod;
    prod = code * mv * 32'd1000;
    return prod >> 7;
  endfunction
endpackage

// File: rtl/mdac_regs.sv
module mdac_regs
  import mdac_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-1:0] CODE_ADDR = CODE_ADDR_DEF,
  parameter logic [AW-1:0] CFG_ADDR  = CFG_ADDR_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] cfg_q,
  output logic [DW-1:0] code_q,
  output logic [DW-1:0] active_q,
  output logic          load_rise
);
  localparam logic [DW-1:0] CFG_MASK = DW'((1 << CFG_USED_W) - 1);

  logic wr_code, wr_cfg;

  assign wr_code   = wr_en && (addr == CODE_ADDR);
  assign wr_cfg    = wr_en && (addr == CFG_ADDR);
  assign load_rise = wr_cfg && wr_data[LOAD_BIT] && !cfg_q[LOAD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      code_q   <= '0;
      active_q <= '0;
    end else begin
      if (wr_code)   code_q   <= wr_data;
      if (wr_cfg)    cfg_q    <= wr_data & CFG_MASK;
      if (load_rise) active_q <= code_q;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == CODE_ADDR)     rd_data = code_q;
    else if (addr == CFG_ADDR) rd_data = cfg_q;
  end
endmodule

// File: rtl/mdac_scale.sv
module mdac_scale
  import mdac_pkg::*;
#(
  parameter int DW    = 8,
  parameter int MV_W  = 11,
  parameter int OUT_W = 22
) (
  input  logic [HS_W-1:0]  hs_sel,
  input  logic [DW-1:0]    code,
  input  logic             en,
  input  logic             oen,
  output logic [MV_W-1:0]  half_scale_mv,
  output logic [OUT_W-1:0] vout_uv,
  output logic             out_live
);
  int unsigned est;

  assign half_scale_mv = MV_W'(hs_millivolts(hs_sel));
  assign est           = est_microvolts(32'(code), 32'(half_scale_mv));
  assign out_live      = en && oen;
  assign vout_uv       = out_live ? OUT_W'(est) : '0;
endmodule

// File: rtl/mdac_ctrl.sv
module mdac_ctrl
  import mdac_pkg::*;
#(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int MV_W  = 11,
  parameter int OUT_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  output logic [DW-1:0]    rd_data,
  output logic [DW-1:0]    active_code,
  output logic             dac_power,
  output logic             dac_connect,
  output logic [MV_W-1:0]  half_scale_mv,
  output logic [OUT_W-1:0] vout_uv
);
  logic [DW-1:0] cfg_q, code_q;
  logic          load_rise;
  logic          out_live;

  mdac_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .cfg_q     (cfg_q),
    .code_q    (code_q),
    .active_q  (active_code),
    .load_rise (load_rise)
  );

  assign dac_power   = cfg_q[EN_BIT];
  assign dac_connect = cfg_q[OEN_BIT];

  mdac_scale #(.DW(DW), .MV_W(MV_W), .OUT_W(OUT_W)) u_scale (
    .hs_sel        (cfg_q[HS_LSB +: HS_W]),
    .code          (active_code),
    .en            (dac_power),
    .oen           (dac_connect),
    .half_scale_mv (half_scale_mv),
    .vout_uv       (vout_uv),
    .out_live      (out_live)
  );
endmodule

// File: rtl/mdac_ctrl_chk.sv
module mdac_ctrl_chk #(
  parameter int AW    = 8,
  parameter int DW    = 8,
  parameter int MV_W  = 11,
  parameter int OUT_W = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic [DW-1:0]    rd_data,
  input logic [DW-1:0]    code_q,
  input logic [DW-1:0]    active_code,
  input logic             load_rise,
  input logic             dac_power,
  input logic             dac_connect,
  input logic [MV_W-1:0]  half_scale_mv,
  input logic [OUT_W-1:0] vout_uv
);
  // R4: a load edge commits the staged code
  p_load_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load_rise |=> active_code == $past(code_q));

  // R5: without a load edge the active code holds
  p_active_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !load_rise |=> $stable(active_code));

  // R7: estimate is zero unless powered and connected
  p_gate_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(dac_power && dac_connect) |-> vout_uv == '0);

  // R3: unused configuration bits read as zero
  p_unused_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 8'hE4) |-> rd_data[7:6] == 2'b00);

  // R6: half-scale value is always one of the table entries
  p_hs_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    half_scale_mv == 400 || half_scale_mv == 500 || half_scale_mv == 600 ||
    half_scale_mv == 700 || half_scale_mv == 800 || half_scale_mv == 900 ||
    half_scale_mv == 1000 || half_scale_mv == 1200);

  // R10: estimate stays below twice the half scale
  p_below_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    32'(vout_uv) < 32'(half_scale_mv) * 32'd2000);
endmodule

bind mdac_ctrl mdac_ctrl_chk #(.AW(AW), .DW(DW), .MV_W(MV_W), .OUT_W(OUT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .addr          (addr),
  .rd_data       (rd_data),
  .code_q        (code_q),
  .active_code   (active_code),
  .load_rise     (load_rise),
  .dac_power     (dac_power),
  .dac_connect   (dac_connect),
  .half_scale_mv (half_scale_mv),
  .vout_uv       (vout_uv)
);

// File: tb/mdac_ctrl_bench.sv
`timescale 1ns/1ps
module mdac_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data, active_code;
  logic        dac_power, dac_connect;
  logic [10:0] half_scale_mv;
  logic [21:0] vout_uv;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  mdac_ctrl u_mdac_ctrl (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .active_code(active_code), .dac_power(dac_power),
    .dac_connect(dac_connect), .half_scale_mv(half_scale_mv), .vout_uv(vout_uv)
  );

  function automatic longint exp_mv(input int sel);
    case (sel)
      0: return 400;  1: return 500;  2: return 600;  3: return 700;
      4: return 800;  5: return 900;  6: return 1000; default: return 1200;
    endcase
  endfunction

  function automatic longint exp_uv(input longint code, input longint mv);
    return (code * mv * 1000) / 128;
  endfunction

  task automatic check(input string req, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  // result due at the accepting edge; sampled at the following falling edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(8'hE3, d); check("R1 code reg", d, 0);
    rd(8'hE4, d); check("R1 cfg reg", d, 0);
    check("R1 active", active_code, 0);
    check("R1 power", dac_power, 0);
    check("R1 connect", dac_connect, 0);
    check("R1 vout", vout_uv, 0);
  endtask

  task automatic t_code_rw();
    logic [7:0] d;
    wr(8'hE3, 8'h5A);
    rd(8'hE3, d); check("R2 code readback", d, 8'h5A);
    check("R5 code write no commit", active_code, 0);
    wr(8'hE3, 8'hA5);
    rd(8'hE3, d); check("R2 code readback 2", d, 8'hA5);
  endtask

  task automatic t_cfg_unused();
    logic [7:0] d;
    wr(8'hE4, 8'hC0);
    rd(8'hE4, d); check("R3 bits 7:6 zero", d, 8'h00);
    wr(8'hE4, 8'hE3);
    rd(8'hE4, d); check("R3 cfg readback", d, 8'h23);
    check("R8 power", dac_power, 1);
    check("R8 connect", dac_connect, 1);
    wr(8'hE4, 8'h00);
  endtask

  task automatic t_load_edge();
    wr(8'hE3, 8'h40);
    wr(8'hE4, 8'h07);
    check("R4 commit on rise", active_code, 8'h40);
    check("R7 vout after commit", vout_uv, exp_uv(64, 400));
    wr(8'hE3, 8'h90);
    check("R5 code write holds", active_code, 8'h40);
    wr(8'hE4, 8'h07);
    check("R5 load held high", active_code, 8'h40);
    wr(8'hE4, 8'h03);
    check("R5 load cleared", active_code, 8'h40);
    wr(8'hE4, 8'h07);
    check("R4 second rise", active_code, 8'h90);
    check("R7 vout code 0x90", vout_uv, exp_uv(144, 400));
  endtask

  task automatic t_table();
    wr(8'hE4, 8'h03);
    wr(8'hE3, 8'h80);
    wr(8'hE4, 8'h07);
    for (int s = 0; s < 8; s++) begin
      wr(8'hE4, 8'((s << 3) | 3));
      check("R6 half scale", half_scale_mv, exp_mv(s));
      check("R10 mid code", vout_uv, exp_mv(s) * 1000);
    end
    wr(8'hE3, 8'hFF);
    wr(8'hE4, 8'h37);
    check("R10 full scale 1000mV", vout_uv, 1992187);
    for (int s = 0; s < 8; s++) begin
      wr(8'hE4, 8'((s << 3) | 3));
      check("R7 full code", vout_uv, exp_uv(255, exp_mv(s)));
    end
  endtask

  task automatic t_gating();
    for (int g = 0; g < 4; g++) begin
      wr(8'hE4, 8'(8'h30 | g));
      check("R8 power", dac_power, g & 1);
      check("R8 connect", dac_connect, (g >> 1) & 1);
      check("R7 gated", vout_uv, (g == 3) ? exp_uv(255, 1000) : 0);
    end
  endtask

  task automatic t_other_addr();
    logic [7:0] d;
    wr(8'hE5, 8'h55);
    rd(8'hE5, d); check("R9 unmapped read", d, 0);
    rd(8'hE3, d); check("R9 code intact", d, 8'hFF);
    rd(8'hE4, d); check("R9 cfg intact", d, 8'h33);
    wr(8'hE2, 8'h07);
    check("R9 no commit", active_code, 8'hFF);
    rd(8'hE4, d); check("R9 cfg intact 2", d, 8'h33);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_code_rw();
    t_cfg_unused();
    t_load_edge();
    t_table();
    t_gating();
    t_other_addr();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule